// File: doc/BRIEF.md
# Cross-Triggered Reload Counter Bank

This block is a bank of up-counting event counters. Any counter that overflows can reload a programmed subset of the bank to preset values in hardware. Software can therefore set two counters with different periods and let the one that overflows first decide what happens next. Suppose the slow "reference" counter wraps first. It reloads both counters, and no sample is taken. Suppose the fast "numerator" counter wraps first. That means the event ratio has crossed the threshold, so a sample request is raised and only the reference counter is reloaded. No software runs on each overflow.

Each counter has four registers: a live count, a reload value, a cause mask and a control word holding count-enable and sample-enable. An event strobe per counter adds one per cycle while the counter is enabled. A single-cycle register port writes and reads the registers. The bank outputs all live counts, a sticky overflow status vector and a one-cycle sample request. A small sequencer has two states. In RUN it only gathers overflows. It enters RELOAD for one cycle to apply the reloads that the previous cycle's overflows requested.

Top module: `xtrig_ctr_bank`

## Requirements
- R1: After reset every count is 0, every cause mask and control word is 0, status and sample outputs are 0, and every reload value equals 2^W minus MAX_PERIOD (2^47 by default).
- R2: Register address = {global(1), counter index(2), field(2)}. Field 0 is the count, 1 the reload value, 2 the cause mask (low N bits), and 3 the control word (bit 0 count-enable, bit 1 sample-enable). Global=1 selects the status register. Reads are combinational and return the written values.
- R3: A reload-value write is accepted only if the value is at least 2^W minus MAX_PERIOD, meaning its period does not exceed MAX_PERIOD. Otherwise the old value is kept.
- R4: A counter adds exactly one at each clock edge where its count-enable is 1 and its strobe is 1. When count-enable is 0 it holds its value.
- R5: An increment from all-ones is an overflow. The count becomes 0 at that edge and the counter's status bit is set at the same edge.
- R6: Status bits are sticky and cleared by writing 1 to the status register. Writing 0 has no effect. A new overflow in the same cycle as a clear leaves the bit set.
- R7: If counter i overflows in cycle t and bit i of counter j's cause mask is 1, counter j holds its reload value after the edge ending cycle t+1.
- R8: A counter whose cause mask lacks its own index is not reloaded by its own overflow. It keeps counting from 0.
- R9: When several counters overflow in the same cycle, the counters reloaded are the union, over all overflowing i, of the counters with mask bit i set.
- R10: sample_vec_o bit i is 1 for exactly the one cycle after counter i overflows, and only if its sample-enable is 1. sample_req_o is the OR of sample_vec_o.
- R11: A reload discards the reloaded counter's increment in that cycle. A software count write overrides both reload and increment, and never produces an overflow.
- R12: The sequencer moves RUN→RELOAD when any reload is requested, stays in RELOAD when new requests arrive, and returns RELOAD→RUN otherwise. Counters that are not reloaded keep counting normally through the RELOAD cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | N | Per-counter event strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | $clog2(N)+3 | Register address |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data (combinational) |
| cnt_o | output | N*W | Live counts, counter i at bits [i*W +: W] |
| ovf_status_o | output | N | Sticky overflow status |
| sample_vec_o | output | N | Per-counter sample request pulse |
| sample_req_o | output | 1 | Any sample request |

## Verification
The hardest cases to reach are collisions in time. These are two counters wrapping on the same edge, a reload landing on a counter that is being incremented or written, and a status clear arriving together with a fresh overflow. The stimulus reaches them by loading counts one step below all-ones through the register port. It then drives the strobes on the chosen cycle. A random phase keeps reload values within a few events of overflow, so wraps and cascaded RELOAD cycles occur every few cycles while a reference model tracks each count.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;

    typedef enum logic [1:0] {
        FLD_COUNT  = 2'd0,
        FLD_RELOAD = 2'd1,
        FLD_CAUSE  = 2'd2,
        FLD_CTRL   = 2'd3
    } fld_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_RELOAD = 1'b1
    } rl_state_e;

    localparam int CTRL_EN  = 0;
    localparam int CTRL_IRQ = 1;

endpackage

// File: rtl/xtrig_ctr_slice.sv
module xtrig_ctr_slice
    import xtrig_pkg::*;
#(
    parameter int          N          = 4,
    parameter int          W          = 48,
    parameter logic [W-1:0] MIN_RELOAD = {1'b1, {(W-1){1'b0}}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt_i,
    input  logic         wr_i,
    input  fld_e         fld_i,
    input  logic [W-1:0] wdata_i,
    input  logic         reload_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] rel_o,
    output logic [N-1:0] mask_o,
    output logic         en_o,
    output logic         irq_o,
    output logic         ovf_o
);

    logic [W-1:0] cnt_q, rel_q;
    logic [N-1:0] mask_q;
    logic         en_q, irq_q;
    logic         wr_cnt, bump;

    assign wr_cnt = wr_i && (fld_i == FLD_COUNT);
    assign bump   = en_q && evt_i && !reload_i && !wr_cnt;
    assign ovf_o  = bump && (cnt_q == '1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rel_q  <= MIN_RELOAD;
            mask_q <= '0;
            en_q   <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_cnt)
                cnt_q <= wdata_i;
            else if (reload_i)
                cnt_q <= rel_q;
            else if (bump)
                cnt_q <= cnt_q + 1'b1;

            if (wr_i && fld_i == FLD_RELOAD && wdata_i >= MIN_RELOAD)
                rel_q <= wdata_i;
            if (wr_i && fld_i == FLD_CAUSE)
                mask_q <= wdata_i[N-1:0];
            if (wr_i && fld_i == FLD_CTRL) begin
                en_q  <= wdata_i[CTRL_EN];
                irq_q <= wdata_i[CTRL_IRQ];
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign rel_o  = rel_q;
    assign mask_o = mask_q;
    assign en_o   = en_q;
    assign irq_o  = irq_q;

endmodule

// File: rtl/xtrig_reload_ctrl.sv
module xtrig_reload_ctrl
    import xtrig_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        ovf_i,
    input  logic [N-1:0][N-1:0] mask_i,
    input  logic [N-1:0]        irq_i,
    output logic [N-1:0]        reload_o,
    output logic [N-1:0]        samp_o,
    output rl_state_e           state_o
);

    rl_state_e    state_q, state_d;
    logic [N-1:0] want_d, pend_q, samp_q;

    // Union of reload requests over all overflowing causes
    always_comb begin
        for (int j = 0; j < N; j++)
            want_d[j] = |(mask_i[j] & ovf_i);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    state_d = (|want_d) ? ST_RELOAD : ST_RUN;
            ST_RELOAD: state_d = (|want_d) ? ST_RELOAD : ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pend_q  <= '0;
            samp_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= want_d;
            samp_q  <= ovf_i & irq_i;
        end
    end

    always_comb begin
        reload_o = '0;
        unique case (state_q)
            ST_RUN:    reload_o = '0;
            ST_RELOAD: reload_o = pend_q;
            default:   reload_o = '0;
        endcase
    end

    assign samp_o  = samp_q;
    assign state_o = state_q;

endmodule

// File: rtl/xtrig_ctr_bank.sv
module xtrig_ctr_bank
    import xtrig_pkg::*;
#(
    parameter int           N          = 4,
    parameter int           W          = 48,
    parameter logic [W-1:0] MAX_PERIOD = {1'b1, {(W-1){1'b0}}},
    localparam int          IW         = $clog2(N),
    localparam int          AW         = IW + 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   evt_i,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [W-1:0]   reg_wdata,
    output logic [W-1:0]   reg_rdata,
    output logic [N*W-1:0] cnt_o,
    output logic [N-1:0]   ovf_status_o,
    output logic [N-1:0]   sample_vec_o,
    output logic           sample_req_o
);

    localparam logic [W-1:0] MIN_RELOAD = (~MAX_PERIOD) + {{(W-1){1'b0}}, 1'b1};

    logic                is_stat;
    fld_e                fld;
    logic [IW-1:0]       idx;
    logic [N-1:0][W-1:0] cnt_a, rel_a;
    logic [N-1:0][N-1:0] mask_a;
    logic [N-1:0]        en_v, irq_v, ovf_v, reload_v, stat_q, stat_clr;
    rl_state_e           state;

    assign is_stat = reg_addr[AW-1];
    assign idx     = reg_addr[IW+1:2];
    assign fld     = fld_e'(reg_addr[1:0]);

    for (genvar g = 0; g < N; g++) begin : g_ctr
        xtrig_ctr_slice #(.N(N), .W(W), .MIN_RELOAD(MIN_RELOAD)) i_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt_i[g]),
            .wr_i     (reg_we && !is_stat && idx == IW'(g)),
            .fld_i    (fld),
            .wdata_i  (reg_wdata),
            .reload_i (reload_v[g]),
            .cnt_o    (cnt_a[g]),
            .rel_o    (rel_a[g]),
            .mask_o   (mask_a[g]),
            .en_o     (en_v[g]),
            .irq_o    (irq_v[g]),
            .ovf_o    (ovf_v[g])
        );
        assign cnt_o[g*W +: W] = cnt_a[g];
    end

    xtrig_reload_ctrl #(.N(N)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf_i    (ovf_v),
        .mask_i   (mask_a),
        .irq_i    (irq_v),
        .reload_o (reload_v),
        .samp_o   (sample_vec_o),
        .state_o  (state)
    );

    // Sticky status, write-1-to-clear, a new overflow wins
    assign stat_clr = (reg_we && is_stat) ? reg_wdata[N-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | ovf_v;
    end

    always_comb begin
        reg_rdata = '0;
        if (is_stat) begin
            reg_rdata[N-1:0] = stat_q;
        end else begin
            unique case (fld)
                FLD_COUNT:  reg_rdata = cnt_a[idx];
                FLD_RELOAD: reg_rdata = rel_a[idx];
                FLD_CAUSE:  reg_rdata[N-1:0] = mask_a[idx];
                FLD_CTRL: begin
                    reg_rdata[CTRL_EN]  = en_v[idx];
                    reg_rdata[CTRL_IRQ] = irq_v[idx];
                end
                default: reg_rdata = '0;
            endcase
        end
    end

    assign ovf_status_o = stat_q;
    assign sample_req_o = |sample_vec_o;

endmodule

// File: rtl/xtrig_ctr_bank_chk.sv
module xtrig_ctr_bank_chk
    import xtrig_pkg::*;
#(
    parameter int           N          = 4,
    parameter int           W          = 48,
    parameter int           AW         = 5,
    parameter logic [W-1:0] MIN_RELOAD = {1'b1, {(W-1){1'b0}}}
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_we,
    input logic [AW-1:0]       reg_addr,
    input logic [W-1:0]        reg_wdata,
    input logic [N-1:0][W-1:0] cnt_a,
    input logic [N-1:0][W-1:0] rel_a,
    input logic [N-1:0]        en_v,
    input logic [N-1:0]        ovf_v,
    input logic [N-1:0]        reload_v,
    input logic [N-1:0]        ovf_status_o,
    input logic [N-1:0]        sample_vec_o,
    input rl_state_e           state
);

    localparam int IW = AW - 3;

    logic [N-1:0] clr;
    assign clr = (reg_we && reg_addr[AW-1]) ? reg_wdata[N-1:0] : '0;

    assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|ovf_status_o) |=> (((($past(ovf_status_o) & ~$past(clr)) & ~ovf_status_o)) == '0));

    assert_reload_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELOAD) |-> $past(|ovf_v));

    for (genvar g = 0; g < N; g++) begin : g_chk
        logic wr_cnt;
        assign wr_cnt = reg_we && !reg_addr[AW-1] && reg_addr[AW-2:2] == IW'(g)
                        && reg_addr[1:0] == 2'd0;

        assert_reload_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
            rel_a[g] >= MIN_RELOAD);

        assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_v[g] && !wr_cnt && !reload_v[g]) |=> $stable(cnt_a[g]));

        assert_wrap_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_v[g] |=> (cnt_a[g] == '0 && ovf_status_o[g]));

        assert_sample_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
            sample_vec_o[g] |-> $past(ovf_v[g]));
    end

endmodule

bind xtrig_ctr_bank xtrig_ctr_bank_chk #(
    .N(N), .W(W), .AW(AW), .MIN_RELOAD(MIN_RELOAD)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .cnt_a        (cnt_a),
    .rel_a        (rel_a),
    .en_v         (en_v),
    .ovf_v        (ovf_v),
    .reload_v     (reload_v),
    .ovf_status_o (ovf_status_o),
    .sample_vec_o (sample_vec_o),
    .state        (state)
);

// File: tb/test_xtrig_ctr_bank.sv
module test_xtrig_ctr_bank;

    localparam int N = 4;
    localparam int W = 48;
    localparam logic [W-1:0] ALL1 = '1;
    localparam logic [W-1:0] MINR = {1'b1, {(W-1){1'b0}}};
    localparam logic [4:0]   STAT = 5'b10000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   evt_i = '0;
    logic           reg_we = 1'b0;
    logic [4:0]     reg_addr = '0;
    logic [W-1:0]   reg_wdata = '0;
    logic [W-1:0]   reg_rdata;
    logic [N*W-1:0] cnt_o;
    logic [N-1:0]   ovf_status_o, sample_vec_o;
    logic           sample_req_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    xtrig_ctr_bank i_xtrig_ctr_bank (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cnt_o(cnt_o), .ovf_status_o(ovf_status_o),
        .sample_vec_o(sample_vec_o), .sample_req_o(sample_req_o)
    );

    // Reference model, advanced on every clock edge from the driven inputs
    logic [W-1:0] m_cnt [N];
    logic [W-1:0] m_rel [N];
    logic [N-1:0] m_mask [N];
    logic [N-1:0] m_en, m_irq, m_pend, m_stat, m_samp;
    logic         m_rl;

    always @(posedge clk) begin
        logic [N-1:0] wrc, rnow, ovf, np;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_cnt[i] = '0; m_rel[i] = MINR; m_mask[i] = '0;
            end
            m_en = '0; m_irq = '0; m_pend = '0; m_stat = '0; m_samp = '0; m_rl = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                wrc[i]  = reg_we && !reg_addr[4] && reg_addr[3:2] == 2'(i) && reg_addr[1:0] == 2'd0;
                rnow[i] = m_rl && m_pend[i];
                ovf[i]  = m_en[i] && evt_i[i] && !rnow[i] && !wrc[i] && m_cnt[i] == ALL1;
            end
            for (int j = 0; j < N; j++) np[j] = |(m_mask[j] & ovf);
            for (int i = 0; i < N; i++) begin
                if (wrc[i]) m_cnt[i] = reg_wdata;
                else if (rnow[i]) m_cnt[i] = m_rel[i];
                else if (m_en[i] && evt_i[i]) m_cnt[i] = m_cnt[i] + 1'b1;
            end
            if (reg_we && !reg_addr[4]) begin
                case (reg_addr[1:0])
                    2'd1: if (reg_wdata >= MINR) m_rel[reg_addr[3:2]] = reg_wdata;
                    2'd2: m_mask[reg_addr[3:2]] = reg_wdata[N-1:0];
                    2'd3: begin
                        m_en[reg_addr[3:2]]  = reg_wdata[0];
                        m_irq[reg_addr[3:2]] = reg_wdata[1];
                    end
                    default: ;
                endcase
            end
            if (reg_we && reg_addr[4]) m_stat = m_stat & ~reg_wdata[N-1:0];
            m_stat = m_stat | ovf;
            m_samp = ovf & m_irq;
            m_pend = np;
            m_rl   = |np;
        end
    end

    function automatic logic [4:0] ra(input int idx, input int fld);
        return {1'b0, 2'(idx), 2'(fld)};
    endfunction

    function automatic logic [W-1:0] cnt(input int i);
        return cnt_o[i*W +: W];
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [4:0] a, input logic [W-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [4:0] a, output logic [W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cyc(input logic [N-1:0] e);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; evt_i = '0; reg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d;
        logic [W-1:0] r0, r1;
        r0 = ALL1 - 48'd199999;
        r1 = ALL1 - 48'd999999;

        // R1 reset state
        do_reset();
        for (int i = 0; i < N; i++) chk("R1 count", cnt(i), '0);
        chk("R1 status", W'(ovf_status_o), '0);
        chk("R1 sample", W'({sample_req_o, sample_vec_o}), '0);
        rreg(ra(0, 1), d); chk("R1 reload", d, MINR);
        rreg(ra(3, 2), d); chk("R1 mask", d, '0);

        // R2 register map
        wreg(ra(2, 0), 48'h0001_2345_6789);
        rreg(ra(2, 0), d); chk("R2 count rd", d, 48'h0001_2345_6789);
        wreg(ra(2, 2), 48'h5);
        rreg(ra(2, 2), d); chk("R2 mask rd", d, 48'h5);
        wreg(ra(2, 3), 48'h3);
        rreg(ra(2, 3), d); chk("R2 ctrl rd", d, 48'h3);

        // R3 reload limit
        wreg(ra(1, 1), 48'h1234);
        rreg(ra(1, 1), d); chk("R3 reject small", d, MINR);
        wreg(ra(1, 1), ALL1 - 48'd9);
        rreg(ra(1, 1), d); chk("R3 accept", d, ALL1 - 48'd9);
        wreg(ra(1, 1), MINR - 1'b1);
        rreg(ra(1, 1), d); chk("R3 reject below floor", d, ALL1 - 48'd9);
        wreg(ra(1, 1), MINR);
        rreg(ra(1, 1), d); chk("R3 accept floor", d, MINR);

        // R4 enable gating
        wreg(ra(3, 0), 48'd5);
        repeat (3) cyc(4'b1000);
        chk("R4 disabled hold", cnt(3), 48'd5);
        wreg(ra(3, 3), 48'h1);
        repeat (3) cyc(4'b1000);
        chk("R4 count", cnt(3), 48'd8);

        // R5 overflow wrap and status
        wreg(ra(3, 0), ALL1);
        cyc(4'b1000);
        chk("R5 wrap", cnt(3), '0);
        chk("R5 status", W'(ovf_status_o), 48'h8);
        chk("R10 no sample when disabled", W'(sample_req_o), '0);

        // R6 write-1-to-clear, set wins
        wreg(STAT, 48'h0);
        chk("R6 write zero", W'(ovf_status_o), 48'h8);
        wreg(STAT, 48'h8);
        chk("R6 clear", W'(ovf_status_o), '0);
        wreg(ra(3, 0), ALL1);
        evt_i = 4'b1000;
        wreg(STAT, 48'h8);
        evt_i = '0;
        chk("R6 set wins", W'(ovf_status_o), 48'h8);

        // Ratio example
        do_reset();
        wreg(ra(0, 1), r0); wreg(ra(0, 2), 48'h2); wreg(ra(0, 3), 48'h3);
        wreg(ra(1, 1), r1); wreg(ra(1, 2), 48'h3); wreg(ra(1, 3), 48'h1);
        wreg(ra(0, 0), r0 + 48'd5); wreg(ra(1, 0), ALL1);
        cyc(4'b0011);
        chk("R5 cause wraps", cnt(1), '0);
        chk("R10 no sample ref wrap", W'({sample_req_o, sample_vec_o}), '0);
        cyc(4'b0000);
        chk("R7 reload c0", cnt(0), r0);
        chk("R7 reload c1", cnt(1), r1);

        wreg(ra(0, 0), ALL1); wreg(ra(1, 0), 48'd1000); wreg(STAT, 48'hF);
        cyc(4'b0011);
        chk("R10 sample vec", W'(sample_vec_o), 48'h1);
        chk("R10 sample req", W'(sample_req_o), 48'h1);
        chk("R4 c1 during", cnt(1), 48'd1001);
        cyc(4'b0011);
        chk("R11 reload beats incr", cnt(1), r1);
        chk("R8 no self reload", cnt(0), 48'd1);
        chk("R10 one cycle pulse", W'(sample_vec_o), '0);
        cyc(4'b0011);
        chk("R12 back to run", cnt(1), r1 + 48'd1);

        // R9 union of simultaneous overflows
        wreg(ra(2, 1), ALL1 - 48'd6); wreg(ra(2, 2), 48'h1);
        wreg(ra(3, 1), ALL1 - 48'd8); wreg(ra(3, 2), 48'h2);
        wreg(ra(0, 0), ALL1); wreg(ra(1, 0), ALL1);
        cyc(4'b0011);
        chk("R10 union sample", W'(sample_vec_o), 48'h1);
        cyc(4'b0000);
        chk("R9 c0", cnt(0), r0);
        chk("R9 c1", cnt(1), r1);
        chk("R9 c2", cnt(2), ALL1 - 48'd6);
        chk("R9 c3", cnt(3), ALL1 - 48'd8);

        // R11 software write priority
        wreg(ra(0, 0), ALL1); wreg(ra(1, 0), 48'd500);
        cyc(4'b0001);
        wreg(ra(1, 0), 48'h77);
        chk("R11 write beats reload", cnt(1), 48'h77);
        chk("R7 c2 by c0", cnt(2), ALL1 - 48'd6);
        wreg(STAT, 48'hF);
        wreg(ra(1, 0), ALL1);
        evt_i = 4'b0010;
        wreg(ra(1, 0), 48'h10);
        evt_i = '0;
        chk("R11 write beats incr", cnt(1), 48'h10);
        chk("R11 no overflow", W'(ovf_status_o), '0);

        // Random phase against the reference model
        do_reset();
        void'($urandom(32'd12345));
        for (int i = 0; i < N; i++) begin
            wreg(ra(i, 1), ALL1 - 48'($urandom_range(0, 19)));
            wreg(ra(i, 2), 48'($urandom_range(0, 15)));
            wreg(ra(i, 3), 48'($urandom_range(1, 3)));
            wreg(ra(i, 0), ALL1 - 48'($urandom_range(0, 7)));
        end
        for (int k = 0; k < 3000; k++) begin
            for (int i = 0; i < N; i++) chk("R7 R9 R11 random count", cnt(i), m_cnt[i]);
            chk("R5 R6 random status", W'(ovf_status_o), W'(m_stat));
            chk("R10 random sample", W'(sample_vec_o), W'(m_samp));
            evt_i = 4'($urandom);
            reg_we = 1'b0;
            if ($urandom_range(0, 15) == 0) begin
                reg_we = 1'b1; reg_addr = STAT; reg_wdata = 48'($urandom_range(0, 15));
            end else if ($urandom_range(0, 31) == 0) begin
                reg_we = 1'b1; reg_addr = ra($urandom_range(0, 3), 0);
                reg_wdata = ALL1 - 48'($urandom_range(0, 7));
            end
            @(negedge clk);
        end
        reg_we = 1'b0; evt_i = '0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule